// File: doc/BRIEF.md
# Register Transfer Executor

This block executes the register-transfer subset of an 8-bit microcontroller instruction set on a private 32-entry by 8-bit register file. It accepts one 16-bit instruction word per cycle and handles three kinds of transfer:

- copying one register into another;
- copying an even-aligned register pair as a 16-bit word;
- loading an 8-bit constant into one of the upper sixteen registers.

Each accepted word retires one cycle later. The block reports every register write it makes on two write-report lanes, pulses a completion strobe, and flags any word outside the three patterns as illegal. It holds no condition flags, so status is never touched.

Instructions arrive on a valid/ready stream. Ready is low during reset and stays high from the first clock edge after reset. The executor never applies back-pressure, so the producer may hold valid high every cycle. A word is taken on each rising edge where valid and ready are both high. The executor writes its register file on that same edge. Because of this, an instruction in the very next cycle reads the updated contents without any stall.

Top module: `xfer_exec`

## Requirements
- R1: Every word taken with valid and ready high produces `done` high for exactly the following cycle. Ready is low in reset and high at every cycle after the first post-reset edge.
- R2: The single-register copy is the word pattern 001011 in bits 15:10. Its destination is {bit 8, bits 7:4} and its source is {bit 9, bits 3:0}. Lane 0 reports the destination index and the source's old value, and the register takes that value.
- R3: The word copy is the pattern 0x01 in bits 15:8. Its destination pair base is 2 x bits 7:4 and its source pair base is 2 x bits 3:0. Both bytes are written in one cycle: lane 0 carries even index 2d with R[2r], and lane 1 carries index 2d+1 with R[2r+1].
- R4: The constant load is the pattern 1110 in bits 15:12. The constant is {bits 11:8, bits 3:0} and the destination is 16 + bits 7:4. Lane 0 reports that index and that constant.
- R5: A word that matches none of the three patterns writes no register. It raises `illegal` together with `done` for one cycle.
- R6: An instruction taken in the cycle right after a write reads the value just written, including when it reads a pair that was just written.
- R7: Reset clears every register to zero and drives all outputs low.
- R8: In a cycle where `done` is low, both write lanes and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Executor can take a word (high after reset) |
| instr_word | input | 16 | Instruction word |
| wr0_en | output | 1 | Lane 0 write report valid |
| wr0_idx | output | 5 | Lane 0 register index |
| wr0_data | output | 8 | Lane 0 value written |
| wr1_en | output | 1 | Lane 1 write report valid (word copy high byte) |
| wr1_idx | output | 5 | Lane 1 register index |
| wr1_data | output | 8 | Lane 1 value written |
| done | output | 1 | One-cycle retire pulse per accepted word |
| illegal | output | 1 | Retired word matched no pattern |

## Verification
The hardest situation to reach is a dependent chain with no idle cycle between steps: a word copy whose source pair was just loaded, or a copy that reads a register that a word copy wrote in the previous cycle. The register contents can only be seen through later copies, so the stimulus holds valid high across whole chains of constant loads, single copies and pair copies. A long random phase then mixes all three kinds with illegal words and occasional gaps. A scoreboard model predicts every reported write and carries register state forward.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int INSN_W  = 16;
  localparam int FIELD_W = 5;
  localparam int IMM_W   = 8;

  typedef enum logic [1:0] {
    XOP_NONE = 2'd0,
    XOP_BYTE = 2'd1,
    XOP_PAIR = 2'd2,
    XOP_KONST = 2'd3
  } xop_e;

  typedef struct packed {
    xop_e               op;
    logic [FIELD_W-1:0] dst;
    logic [FIELD_W-1:0] src;
    logic [IMM_W-1:0]   imm;
  } xdec_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output xdec_t             dec
);
  always_comb begin
    dec = '0;
    if (word[15:10] == 6'b001011) begin
      dec.op  = XOP_BYTE;
      dec.dst = {word[8], word[7:4]};
      dec.src = {word[9], word[3:0]};
    end else if (word[15:8] == 8'h01) begin
      dec.op  = XOP_PAIR;
      dec.dst = {word[7:4], 1'b0};
      dec.src = {word[3:0], 1'b0};
    end else if (word[15:12] == 4'he) begin
      dec.op  = XOP_KONST;
      dec.dst = {1'b1, word[7:4]};
      dec.imm = {word[11:8], word[3:0]};
    end else begin
      dec.op  = XOP_NONE;
    end
  end
endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int RD_PORTS = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we0,
  input  logic [IDX_W-1:0]                 wa0,
  input  logic [DATA_W-1:0]                wd0,
  input  logic                             we1,
  input  logic [IDX_W-1:0]                 wa1,
  input  logic [DATA_W-1:0]                wd1,
  input  logic [RD_PORTS-1:0][IDX_W-1:0]   ra,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rd
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (we0 && wa0 == IDX_W'(i)) begin
          regs[i] <= wd0;
        end else if (we1 && wa1 == IDX_W'(i)) begin
          regs[i] <= wd1;
        end
      end
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    assign rd[p] = regs[ra[p]];
  end
endmodule

// File: rtl/xfer_issue.sv
module xfer_issue
  import xfer_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              accept,
  input  xdec_t             dec,
  input  logic [DATA_W-1:0] rd_lo,
  input  logic [DATA_W-1:0] rd_hi,
  output logic [IDX_W-1:0]  ra_lo,
  output logic [IDX_W-1:0]  ra_hi,
  output logic              we0,
  output logic [IDX_W-1:0]  wa0,
  output logic [DATA_W-1:0] wd0,
  output logic              we1,
  output logic [IDX_W-1:0]  wa1,
  output logic [DATA_W-1:0] wd1,
  output logic              bad
);
  logic [IDX_W-1:0] dst_i;
  logic [IDX_W-1:0] src_i;

  assign dst_i = IDX_W'(dec.dst);
  assign src_i = IDX_W'(dec.src);

  // Pair reads: the low port sees the even source, the high port its odd twin.
  assign ra_lo = src_i;
  assign ra_hi = {src_i[IDX_W-1:1], 1'b1};

  always_comb begin
    we0 = accept && (dec.op != XOP_NONE);
    wa0 = dst_i;
    wd0 = (dec.op == XOP_KONST) ? DATA_W'(dec.imm) : rd_lo;
    we1 = accept && (dec.op == XOP_PAIR);
    wa1 = {dst_i[IDX_W-1:1], 1'b1};
    wd1 = rd_hi;
    bad = accept && (dec.op == XOP_NONE);
  end
endmodule

// File: rtl/xfer_exec.sv
module xfer_exec
  import xfer_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [INSN_W-1:0] instr_word,
  output logic              wr0_en,
  output logic [IDX_W-1:0]  wr0_idx,
  output logic [DATA_W-1:0] wr0_data,
  output logic              wr1_en,
  output logic [IDX_W-1:0]  wr1_idx,
  output logic [DATA_W-1:0] wr1_data,
  output logic              done,
  output logic              illegal
);
  xdec_t                     dec;
  logic                      accept;
  logic [1:0][IDX_W-1:0]     ra;
  logic [1:0][DATA_W-1:0]    rd;
  logic                      we0, we1, bad;
  logic [IDX_W-1:0]          wa0, wa1;
  logic [DATA_W-1:0]         wd0, wd1;

  assign accept = instr_valid && instr_ready;

  xfer_decode u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  xfer_issue #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_iss (
    .accept (accept),
    .dec    (dec),
    .rd_lo  (rd[0]),
    .rd_hi  (rd[1]),
    .ra_lo  (ra[0]),
    .ra_hi  (ra[1]),
    .we0    (we0),
    .wa0    (wa0),
    .wd0    (wd0),
    .we1    (we1),
    .wa1    (wa1),
    .wd1    (wd1),
    .bad    (bad)
  );

  xfer_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .RD_PORTS(2)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we0   (we0),
    .wa0   (wa0),
    .wd0   (wd0),
    .we1   (we1),
    .wa1   (wa1),
    .wd1   (wd1),
    .ra    (ra),
    .rd    (rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_ready <= 1'b0;
      done        <= 1'b0;
      illegal     <= 1'b0;
      wr0_en      <= 1'b0;
      wr0_idx     <= '0;
      wr0_data    <= '0;
      wr1_en      <= 1'b0;
      wr1_idx     <= '0;
      wr1_data    <= '0;
    end else begin
      instr_ready <= 1'b1;
      done        <= accept;
      illegal     <= bad;
      wr0_en      <= we0;
      wr0_idx     <= we0 ? wa0 : '0;
      wr0_data    <= we0 ? wd0 : '0;
      wr1_en      <= we1;
      wr1_idx     <= we1 ? wa1 : '0;
      wr1_data    <= we1 ? wd1 : '0;
    end
  end
endmodule

// File: rtl/xfer_exec_chk.sv
module xfer_exec_chk #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [15:0]       instr_word,
  input logic              wr0_en,
  input logic [IDX_W-1:0]  wr0_idx,
  input logic [DATA_W-1:0] wr0_data,
  input logic              wr1_en,
  input logic [IDX_W-1:0]  wr1_idx,
  input logic [DATA_W-1:0] wr1_data,
  input logic              done,
  input logic              illegal
);
  p_done_after_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr_ready) |=> done);

  p_done_has_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(instr_valid && instr_ready));

  p_pair_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> (wr0_en && !wr0_idx[0] && wr1_idx == wr0_idx + IDX_W'(1)));

  p_konst_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_valid && instr_ready && instr_word[15:12] == 4'he) |->
      (wr0_en && !wr1_en && wr0_idx[IDX_W-1] &&
       wr0_data == DATA_W'({$past(instr_word[11:8]), $past(instr_word[3:0])})));

  p_illegal_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !wr0_en && !wr1_en));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!wr0_en && !wr1_en && !illegal));
endmodule

bind xfer_exec xfer_exec_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_ready (instr_ready),
  .instr_word  (instr_word),
  .wr0_en      (wr0_en),
  .wr0_idx     (wr0_idx),
  .wr0_data    (wr0_data),
  .wr1_en      (wr1_en),
  .wr1_idx     (wr1_idx),
  .wr1_data    (wr1_data),
  .done        (done),
  .illegal     (illegal)
);

// File: tb/test_xfer_exec.sv
module test_xfer_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_word = '0;
  logic        instr_ready;
  logic        wr0_en, wr1_en, done, illegal;
  logic [4:0]  wr0_idx, wr1_idx;
  logic [7:0]  wr0_data, wr1_data;

  always #10 clk = ~clk;

  xfer_exec i_xfer_exec (
    .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr_ready (instr_ready),
    .instr_word (instr_word), .wr0_en (wr0_en), .wr0_idx (wr0_idx), .wr0_data (wr0_data),
    .wr1_en (wr1_en), .wr1_idx (wr1_idx), .wr1_data (wr1_data), .done (done), .illegal (illegal)
  );

  typedef struct {
    logic       e0; logic [4:0] i0; logic [7:0] d0;
    logic       e1; logic [4:0] i1; logic [7:0] d1;
    logic       ill; string tag;
  } exp_t;

  exp_t       sb[$];
  logic [7:0] model [32];
  int         total = 0;
  int         bad = 0;
  bit         mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] enc_mov(input int d, input int r);
    logic [4:0] dd = 5'(d), rr = 5'(r);
    return {6'b001011, rr[4], dd[4], dd[3:0], rr[3:0]};
  endfunction
  function automatic logic [15:0] enc_movw(input int d, input int r);
    logic [4:0] dd = 5'(d), rr = 5'(r);
    return {8'h01, dd[4:1], rr[4:1]};
  endfunction
  function automatic logic [15:0] enc_ldi(input int d, input logic [7:0] k);
    logic [4:0] dd = 5'(d);
    return {4'he, k[7:4], dd[3:0], k[3:0]};
  endfunction

  // Driver: predicts the write reports from the requirements, updates the model, presents the word.
  task automatic send(input logic [15:0] w);
    exp_t e;
    int   d, r;
    e = '{default: '0, tag: ""};
    @(negedge clk);
    if (w[15:10] == 6'b001011) begin
      d = {w[8], w[7:4]}; r = {w[9], w[3:0]};
      e.e0 = 1; e.i0 = 5'(d); e.d0 = model[r]; e.tag = "R2/R6";
      model[d] = e.d0;
    end else if (w[15:8] == 8'h01) begin
      d = 2 * w[7:4]; r = 2 * w[3:0];
      e.e0 = 1; e.i0 = 5'(d); e.d0 = model[r];
      e.e1 = 1; e.i1 = 5'(d + 1); e.d1 = model[r + 1]; e.tag = "R3/R6";
      model[d] = e.d0; model[d + 1] = e.d1;
    end else if (w[15:12] == 4'he) begin
      d = 16 + w[7:4];
      e.e0 = 1; e.i0 = 5'(d); e.d0 = {w[11:8], w[3:0]}; e.tag = "R4";
      model[d] = e.d0;
    end else begin
      e.ill = 1; e.tag = "R5";
    end
    sb.push_back(e);
    instr_valid = 1'b1;
    instr_word  = w;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      instr_valid = 1'b0;
      instr_word  = 16'hffff;
    end
  endtask

  // Monitor: one cycle after each accepted word, compares the reported writes.
  always @(negedge clk) begin
    if (mon_on) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R1", "done without pending word", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(wr0_en == e.e0, e.tag, "wr0_en", wr0_en, e.e0);
          if (e.e0) begin
            chk(wr0_idx == e.i0, e.tag, "wr0_idx", wr0_idx, e.i0);
            chk(wr0_data == e.d0, e.tag, "wr0_data", wr0_data, e.d0);
          end
          chk(wr1_en == e.e1, e.tag, "wr1_en", wr1_en, e.e1);
          if (e.e1) begin
            chk(wr1_idx == e.i1, e.tag, "wr1_idx", wr1_idx, e.i1);
            chk(wr1_data == e.d1, e.tag, "wr1_data", wr1_data, e.d1);
          end
          chk(illegal == e.ill, e.tag, "illegal", illegal, e.ill);
        end
      end else begin
        chk(!wr0_en && !wr1_en && !illegal, "R8", "quiet when not done",
            {wr0_en, wr1_en, illegal}, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R7: outputs low while in reset
    chk(!done && !wr0_en && !wr1_en && !illegal && !instr_ready, "R7", "outputs in reset",
        {done, wr0_en, wr1_en, illegal, instr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(instr_ready == 1'b1, "R1", "ready after reset", instr_ready, 1);
    mon_on = 1'b1;

    // R7: registers read as zero after reset
    send(enc_mov(1, 30));
    send(enc_movw(10, 26));
    idle(2);

    // R4: constant loads into upper registers
    send(enc_ldi(16, 8'ha5));
    send(enc_ldi(31, 8'h3c));
    send(enc_ldi(17, 8'h5a));
    send(enc_ldi(18, 8'hff));
    send(enc_ldi(19, 8'h01));
    idle(1);

    // R6: back-to-back dependent chains
    send(enc_ldi(20, 8'h81));
    send(enc_mov(5, 20));
    send(enc_mov(21, 5));
    send(enc_movw(24, 16));
    send(enc_movw(2, 24));
    send(enc_mov(0, 3));
    send(enc_mov(16, 16));
    send(enc_ldi(22, 8'h7e));
    send(enc_movw(12, 22));
    idle(2);

    // R5: illegal words, then read back the registers they could have touched
    send(16'h0000);
    send(16'hffff);
    send(16'h2800);
    send(16'h0200);
    send(16'h9000);
    idle(1);
    send(enc_mov(6, 2));
    send(enc_movw(8, 12));
    send(enc_mov(7, 31));
    idle(1);

    // Random mix of all kinds with gaps
    for (int n = 0; n < 300; n++) begin
      int kind;
      kind = $urandom % 5;
      case (kind)
        0: send(enc_mov($urandom % 32, $urandom % 32));
        1: send(enc_movw($urandom % 32, $urandom % 32));
        2: send(enc_ldi(16 + $urandom % 16, 8'($urandom)));
        3: send({4'hf, 12'($urandom)});
        default: idle(1 + $urandom % 2);
      endcase
    end
    idle(3);
    chk(sb.size() == 0, "R1", "every word retired", sb.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule